// File: doc/BRIEF.md
# Slave Port Arbiter with Default-Master Parking

This block decides which of six bus masters drives a single slave port of an on-chip crossbar. Each master raises a request and keeps it up for the length of its burst. The current owner ends its tenure with a burst-end strobe. The arbiter then hands the port to the next requester in the same clock edge, or lets the port fall idle. Master 2 is normally the peripheral DMA engine. Its traffic is the usual reason to tune the arbiter.

Two configuration words are written through a plain synchronous write port. The first word selects the arbitration type: round-robin, or fixed priority. It also selects what the idle port does, called parking: the port can grant nothing, grant the most recent owner, or grant one programmed master. The same word sets a limit on slot length, counted in cycles. The second word holds a 2-bit priority level for each master.

Parking on a programmed master gives that master zero-latency access. Its grant is already high while the port is idle, so the cycle in which its request rises is already a granted cycle.

Top module: `slave_arbiter_park`

## Requirements
- R1: After reset no grant is high and `owner_vld_o` is low. The configuration word resets to 0x00000010, which means round-robin, no parking and a 16-cycle slot. The priority word resets to 0, so every master is at level 0.
- R2: At most one grant bit is high in any cycle. While the port is busy, the grant stays on the owner until the owner raises `burst_end_i` or its slot expires.
- R3: With parking type 0 (none), an idle port drives all grants low. A request is granted starting with the cycle after it is first seen, which is one arbitration cycle.
- R4: Round-robin, arbitration type 0 in bits [25:24], searches the requesters starting at the master numbered one above the most recent owner, wrapping from 5 to 0.
- R5: Fixed priority, arbitration type 1, grants the requester with the highest level. Master m's level sits at bits [4m+1:4m] of the priority word, which is written when `cfg_sel_i` is 1. When several requesters share the highest level, the lowest-numbered one wins. With the priority word at 0x00200300, master 2 is highest and master 5 is next.
- R6: The configuration word, written when `cfg_sel_i` is 0, holds the following fields. The slot limit sits in bits [7:0]. The parking type sits in bits [17:16], with 0 = none, 1 = last owner, 2 = fixed and 3 = none. The parked master number sits in bits [20:18]; a number above 5 parks nowhere. The arbitration type sits in bits [25:24].
- R7: With parking type 2, the idle port holds the grant of the programmed master. If that master requests while the port is idle, it gets the grant in the same cycle and becomes owner at the next edge. Writing 0x010A0010 selects fixed priority and parks on master 2.
- R8: With parking type 1, the idle port holds the grant of the most recent owner.
- R9: A slot limit L other than 0 ends a tenure after L busy cycles, but only if another master is requesting; with no other requester the owner keeps the port. A limit of 0 never ends a tenure.
- R10: When a tenure ends and other masters are requesting, one of them becomes owner at that same edge, with no idle cycle. The old owner is left out of that choice.
- R11: If the parked master requests and raises `burst_end_i` in the same idle cycle, its single-cycle access completes and the port stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 6 | Request, one bit per master |
| burst_end_i | input | 1 | The owner (or the parked master) signals the last cycle of its access |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | Write target: 0 = configuration word, 1 = priority word |
| cfg_wdata_i | input | 32 | Configuration write data |
| grant_o | output | 6 | Grant, one-hot or all low |
| owner_o | output | 3 | Number of the current owner; 0 while idle |
| owner_vld_o | output | 1 | High while the port is owned |

## Verification
The internal state that matters here is the owner register, the last-owner pointer and the slot counter. A wrong owner register shows up on `grant_o` and `owner_o` in the cycle right after the edge that loaded it. A wrong last-owner pointer stays hidden until the next round-robin choice, or until the next idle cycle under last-owner parking; at that point the wrong master receives the grant. A wrong slot counter shows up as a handover that comes one or more cycles early or late while a second master waits. The bench compares every cycle against an independent model, so each of these errors is reported at the first port cycle in which it becomes visible.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;

  // configuration word field positions
  localparam int SLOT_LSB   = 0;
  localparam int SLOT_BITS  = 8;
  localparam int PARK_LSB   = 16;
  localparam int PARK_BITS  = 2;
  localparam int FID_LSB    = 18;
  localparam int FID_BITS   = 3;
  localparam int ARB_LSB    = 24;
  localparam int ARB_BITS   = 2;

  // priority word: one level field per master, fixed stride
  localparam int PRI_STRIDE = 4;

  localparam logic [31:0] CFG_RST = 32'h0000_0010;
  localparam logic [31:0] PRI_RST = 32'h0000_0000;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_e;

  typedef enum logic [1:0] {
    ARB_RR    = 2'd0,
    ARB_FP    = 2'd1,
    ARB_RSV2  = 2'd2,
    ARB_RSV3  = 2'd3
  } arb_e;

endpackage

// File: rtl/slv_arb_rst_sync.sv
module slv_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign srst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/slv_arb_cfg_regs.sv
module slv_arb_cfg_regs
  import slv_arb_pkg::*;
#(
  parameter int N_MST  = 6,
  parameter int LVL_W  = 2,
  parameter int SLOT_W = SLOT_BITS
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic                   sel_i,
  input  logic [31:0]            wdata_i,
  output logic [SLOT_W-1:0]      slot_lim_o,
  output park_e                  park_o,
  output logic [FID_BITS-1:0]    fid_o,
  output arb_e                   arb_o,
  output logic [N_MST*LVL_W-1:0] lvl_o
);

  localparam int LVL_TOT = N_MST * LVL_W;

  logic                cfg_en, pri_en;
  logic [SLOT_W-1:0]   slot_q, slot_d;
  park_e               park_q, park_d;
  logic [FID_BITS-1:0] fid_q, fid_d;
  arb_e                arb_q, arb_d;
  logic [LVL_TOT-1:0]  lvl_q, lvl_d;
  logic                unused_wbits;

  assign cfg_en       = we_i & ~sel_i;
  assign pri_en       = we_i &  sel_i;
  assign unused_wbits = ^wdata_i;

  // next state: configuration word fields
  always_comb begin
    slot_d = slot_q;
    park_d = park_q;
    fid_d  = fid_q;
    arb_d  = arb_q;
    if (cfg_en) begin
      slot_d = wdata_i[SLOT_LSB +: SLOT_W];
      park_d = park_e'(wdata_i[PARK_LSB +: PARK_BITS]);
      fid_d  = wdata_i[FID_LSB +: FID_BITS];
      arb_d  = arb_e'(wdata_i[ARB_LSB +: ARB_BITS]);
    end
  end

  // next state: one level field per master
  for (genvar m = 0; m < N_MST; m++) begin : g_lvl
    assign lvl_d[m*LVL_W +: LVL_W] = pri_en ? wdata_i[m*PRI_STRIDE +: LVL_W]
                                            : lvl_q[m*LVL_W +: LVL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= CFG_RST[SLOT_LSB +: SLOT_W];
      park_q <= park_e'(CFG_RST[PARK_LSB +: PARK_BITS]);
      fid_q  <= CFG_RST[FID_LSB +: FID_BITS];
      arb_q  <= arb_e'(CFG_RST[ARB_LSB +: ARB_BITS]);
    end else if (cfg_en) begin
      slot_q <= slot_d;
      park_q <= park_d;
      fid_q  <= fid_d;
      arb_q  <= arb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
    end else if (pri_en) begin
      lvl_q <= lvl_d;
    end
  end

  assign slot_lim_o = slot_q;
  assign park_o     = park_q;
  assign fid_o      = fid_q;
  assign arb_o      = arb_q;
  assign lvl_o      = lvl_q;

endmodule

// File: rtl/slv_arb_pick.sv
module slv_arb_pick #(
  parameter int N_MST = 6,
  parameter int LVL_W = 2,
  parameter int IDW   = $clog2(N_MST)
) (
  input  logic [N_MST-1:0]       req_i,
  input  logic                   fp_i,
  input  logic [N_MST*LVL_W-1:0] lvl_i,
  input  logic [IDW-1:0]         last_i,
  output logic [IDW-1:0]         win_o,
  output logic                   vld_o
);

  logic [LVL_W-1:0] lvl_a [N_MST];

  for (genvar m = 0; m < N_MST; m++) begin : g_unpack
    assign lvl_a[m] = lvl_i[m*LVL_W +: LVL_W];
  end

  always_comb begin
    logic [LVL_W-1:0] best;
    int               idx;
    win_o = '0;
    vld_o = 1'b0;
    best  = '0;
    idx   = 0;
    if (fp_i) begin
      // strict compare keeps the lowest-numbered master on a tie
      for (int m = 0; m < N_MST; m++) begin
        if (req_i[m] && (!vld_o || (lvl_a[m] > best))) begin
          vld_o = 1'b1;
          win_o = IDW'(m);
          best  = lvl_a[m];
        end
      end
    end else begin
      // rotate the search to begin just above the most recent owner
      for (int k = 1; k <= N_MST; k++) begin
        idx = (int'(last_i) + k) % N_MST;
        if (!vld_o && req_i[idx]) begin
          vld_o = 1'b1;
          win_o = IDW'(idx);
        end
      end
    end
  end

  // R4, R5: a reported winner is always a requester
  always_comb begin
    if (vld_o) begin
      p_win_requests_r4: assert (req_i[win_o]);
    end
  end

endmodule

// File: rtl/slv_arb_slot_timer.sv
module slv_arb_slot_timer #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [SLOT_W-1:0] lim_i,
  output logic              hit_o
);

  localparam logic [SLOT_W-1:0] CNT_MAX = '1;

  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  assign cnt_en = load_i | (run_i & (cnt_q != CNT_MAX));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = '0;
    end else if (run_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // cnt_q counts busy cycles already used in the current tenure
  assign hit_o = run_i & (lim_i != '0) & (cnt_q >= (lim_i - 1'b1));

  // R9: the busy-cycle count advances by exactly one per owned cycle
  p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && (cnt_q != CNT_MAX)) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/slave_arbiter_park.sv
module slave_arbiter_park
  import slv_arb_pkg::*;
#(
  parameter int N_MST  = 6,
  parameter int LVL_W  = 2,
  parameter int SLOT_W = SLOT_BITS,
  parameter int IDW    = $clog2(N_MST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req_i,
  input  logic             burst_end_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [31:0]      cfg_wdata_i,
  output logic [N_MST-1:0] grant_o,
  output logic [IDW-1:0]   owner_o,
  output logic             owner_vld_o
);

  logic                   srst_n;
  logic [SLOT_W-1:0]      slot_lim;
  park_e                  park_type;
  logic [FID_BITS-1:0]    fid;
  arb_e                   arb_type;
  logic [N_MST*LVL_W-1:0] lvl;

  logic                   busy_q, busy_d;
  logic [IDW-1:0]         own_q, own_d;
  logic [IDW-1:0]         last_q, last_d;
  logic                   tmo_load, tmo_hit, tmo_rel;
  logic [N_MST-1:0]       own_oh, park_oh, others;
  logic                   park_ok, park_req;
  logic [IDW-1:0]         park_id;
  logic [IDW-1:0]         win;
  logic                   win_vld;

  slv_arb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk      (clk),
    .arst_n   (rst_n),
    .srst_n_o (srst_n)
  );

  slv_arb_cfg_regs #(
    .N_MST  (N_MST),
    .LVL_W  (LVL_W),
    .SLOT_W (SLOT_W)
  ) i_cfg_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .slot_lim_o (slot_lim),
    .park_o     (park_type),
    .fid_o      (fid),
    .arb_o      (arb_type),
    .lvl_o      (lvl)
  );

  // parking target
  assign park_ok = (park_type == PARK_LAST) ||
                   ((park_type == PARK_FIXED) && (int'(fid) < N_MST));
  assign park_id = (park_type == PARK_LAST) ? last_q : IDW'(fid);

  for (genvar m = 0; m < N_MST; m++) begin : g_onehot
    assign own_oh[m]  = (own_q == IDW'(m));
    assign park_oh[m] = park_ok && (park_id == IDW'(m));
  end

  assign park_req = |(req_i & park_oh);
  assign others   = busy_q ? (req_i & ~own_oh) : req_i;

  slv_arb_pick #(
    .N_MST (N_MST),
    .LVL_W (LVL_W),
    .IDW   (IDW)
  ) i_pick (
    .req_i  (others),
    .fp_i   (arb_type == ARB_FP),
    .lvl_i  (lvl),
    .last_i (last_q),
    .win_o  (win),
    .vld_o  (win_vld)
  );

  slv_arb_slot_timer #(.SLOT_W(SLOT_W)) i_slot_timer (
    .clk    (clk),
    .rst_n  (srst_n),
    .load_i (tmo_load),
    .run_i  (busy_q),
    .lim_i  (slot_lim),
    .hit_o  (tmo_hit)
  );

  assign tmo_rel = tmo_hit & (|others);

  // ownership next state
  always_comb begin
    busy_d   = busy_q;
    own_d    = own_q;
    last_d   = last_q;
    tmo_load = 1'b0;
    if (busy_q) begin
      if (burst_end_i || tmo_rel) begin
        if (win_vld) begin
          own_d    = win;
          last_d   = win;
          tmo_load = 1'b1;
        end else begin
          busy_d = 1'b0;
        end
      end
    end else if (park_req) begin
      last_d = park_id;
      if (!burst_end_i) begin
        busy_d   = 1'b1;
        own_d    = park_id;
        tmo_load = 1'b1;
      end
    end else if (win_vld) begin
      busy_d   = 1'b1;
      own_d    = win;
      last_d   = win;
      tmo_load = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      busy_q <= 1'b0;
      own_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      own_q  <= own_d;
      last_q <= last_d;
    end
  end

  assign grant_o     = busy_q ? own_oh : park_oh;
  assign owner_o     = busy_q ? own_q : '0;
  assign owner_vld_o = busy_q;

  // R2: never more than one grant
  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0(grant_o));

  // R2: ownership persists while no release condition is present
  p_owner_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_q && !burst_end_i && !tmo_rel) |=> (busy_q && $stable(own_q)));

  // R3: without parking a request costs one arbitration cycle
  p_arb_cycle_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_q && (park_type == PARK_NONE) && (|req_i)) |=> owner_vld_o);

  // R7: parked master is granted in the cycle it requests
  p_park_zero_wait_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_q && (park_type == PARK_FIXED) && (int'(fid) < N_MST) && req_i[fid])
      |-> grant_o[fid]);

  // R9: slot expiry with a waiter moves ownership
  p_slot_handover_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_q && tmo_hit && (|others)) |=> (busy_q && (own_q != $past(own_q))));

  // R10: burst end with waiters hands over without an idle cycle
  p_handover_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (busy_q && burst_end_i && (|others)) |=> (busy_q && (own_q != $past(own_q))));

  // R11: single-cycle parked access leaves the port idle
  p_park_done_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (!busy_q && park_req && burst_end_i) |=> !owner_vld_o);

endmodule

// File: tb/test_slave_arbiter_park.sv
module test_slave_arbiter_park;

  localparam int CLK_PERIOD = 10;
  localparam int NM = 6;

  logic          clk;
  logic          rst_n;
  logic [NM-1:0] req;
  logic          be;
  logic          we;
  logic          sel;
  logic [31:0]   wd;
  logic [NM-1:0] grant;
  logic [2:0]    owner;
  logic          owner_vld;

  int n_chk  = 0;
  int n_fail = 0;

  // reference model state
  bit          m_busy;
  int          m_own, m_last, m_cnt;
  logic [31:0] m_cfg, m_pri;

  slave_arbiter_park i_slave_arbiter_park (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req),
    .burst_end_i (be),
    .cfg_we_i    (we),
    .cfg_sel_i   (sel),
    .cfg_wdata_i (wd),
    .grant_o     (grant),
    .owner_o     (owner),
    .owner_vld_o (owner_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic int pick(logic [NM-1:0] r, logic [31:0] cfg, logic [31:0] pri, int last);
    int w;
    int best;
    w = -1;
    best = -1;
    if (cfg[25:24] == 2'd1) begin
      for (int m = 0; m < NM; m++) begin
        if (r[m] && (int'(pri[4*m +: 2]) > best)) begin
          w = m;
          best = int'(pri[4*m +: 2]);
        end
      end
    end else begin
      for (int k = 1; k <= NM; k++) begin
        if (w < 0 && r[(last + k) % NM]) w = (last + k) % NM;
      end
    end
    return w;
  endfunction

  function automatic bit park_ok();
    return (m_cfg[17:16] == 2'd1) ||
           (m_cfg[17:16] == 2'd2 && int'(m_cfg[20:18]) < NM);
  endfunction

  function automatic int park_id();
    return (m_cfg[17:16] == 2'd1) ? m_last : int'(m_cfg[20:18]);
  endfunction

  function automatic logic [NM-1:0] exp_grant();
    if (m_busy) return NM'(1) << m_own;
    if (park_ok()) return NM'(1) << park_id();
    return '0;
  endfunction

  task automatic model_step(input logic [NM-1:0] r, input logic e, input logic w,
                            input logic s, input logic [31:0] d);
    logic [NM-1:0] oth;
    int slot, nw;
    bit expd;
    oth  = m_busy ? (r & ~(NM'(1) << m_own)) : r;
    slot = int'(m_cfg[7:0]);
    if (m_busy) begin
      expd = (slot != 0) && (m_cnt >= slot - 1) && (oth != 0);
      if (e || expd) begin
        nw = pick(oth, m_cfg, m_pri, m_last);
        if (nw >= 0) begin
          m_own = nw; m_last = nw; m_cnt = 0;
        end else begin
          m_busy = 0; m_cnt = 0;
        end
      end else if (m_cnt < 255) begin
        m_cnt++;
      end
    end else if (park_ok() && r[park_id()]) begin
      m_last = park_id();
      if (!e) begin
        m_busy = 1; m_own = m_last; m_cnt = 0;
      end
    end else begin
      nw = pick(r, m_cfg, m_pri, m_last);
      if (nw >= 0) begin
        m_busy = 1; m_own = nw; m_last = nw; m_cnt = 0;
      end
    end
    if (w) begin
      if (s) m_pri = d;
      else   m_cfg = d;
    end
  endtask

  // one clock cycle: drive, compare with the model, advance the model
  task automatic step(input logic [NM-1:0] r, input logic e, input logic w,
                      input logic s, input logic [31:0] d, input string tag);
    @(posedge clk);
    #2;
    req = r; be = e; we = w; sel = s; wd = d;
    #1;
    chk({tag, " grant"}, 32'(grant), 32'(exp_grant()));
    chk({tag, " valid"}, 32'(owner_vld), 32'(m_busy));
    chk({tag, " owner"}, 32'(owner), m_busy ? m_own : 0);
    model_step(r, e, w, s, d);
  endtask

  task automatic run(input logic [NM-1:0] r, input logic e, input string tag);
    step(r, e, 1'b0, 1'b0, 32'h0, tag);
  endtask

  task automatic wr(input logic s, input logic [31:0] d, input string tag);
    step('0, 1'b0, 1'b1, s, d, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20111024));
    rst_n = 1'b0; req = '0; be = 1'b0; we = 1'b0; sel = 1'b0; wd = '0;
    m_busy = 0; m_own = 0; m_last = 0; m_cnt = 0;
    m_cfg = 32'h0000_0010; m_pri = 32'h0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 reset grant", 32'(grant), 32'h0);
    chk("R1 reset valid", 32'(owner_vld), 32'h0);

    // R3: one arbitration cycle, no parking after reset
    run(6'b000100, 1'b0, "R3");
    chk("R3 idle grant low", 32'(grant), 32'h0);
    run(6'b000100, 1'b0, "R3");
    chk("R3 granted next cycle", 32'(grant), 32'h04);
    run(6'b000100, 1'b1, "R2");
    run(6'b000000, 1'b0, "R3");
    chk("R3 idle after end", 32'(grant), 32'h0);

    // R4 and R10: rotation after owner 2, handover without idle cycle
    run(6'b100011, 1'b0, "R4");
    run(6'b100011, 1'b1, "R4");
    chk("R4 after 2 comes 5", 32'(grant), 32'h20);
    run(6'b000011, 1'b0, "R10");
    chk("R10 wrap to 0", 32'(grant), 32'h01);
    run(6'b000010, 1'b1, "R10");
    run(6'b000000, 1'b0, "R10");
    chk("R10 old owner skipped", 32'(grant), 32'h02);
    run(6'b000000, 1'b1, "R2");
    run(6'b000000, 1'b0, "R2");

    // R9 with the R1 default 16-cycle slot
    run(6'b000011, 1'b0, "R9");
    for (int i = 0; i < 16; i++) begin
      run(6'b000011, 1'b0, "R9");
      chk("R9 R1 owner within slot", 32'(grant), 32'h01);
    end
    run(6'b000011, 1'b0, "R9");
    chk("R9 handover at slot end", 32'(grant), 32'h02);
    for (int i = 0; i < 20; i++) run(6'b000010, 1'b0, "R9");
    chk("R9 no waiter keeps owner", 32'(grant), 32'h02);
    run(6'b000000, 1'b1, "R2");

    // R9: limit 0 is unlimited
    wr(1'b0, 32'h0000_0000, "R6");
    run(6'b000011, 1'b0, "R9");
    for (int i = 0; i < 40; i++) run(6'b000011, 1'b0, "R9");
    chk("R9 unlimited slot", 32'(grant), 32'h01);
    run(6'b000000, 1'b1, "R2");

    // R5, R7: fixed priority and parking on master 2
    wr(1'b1, 32'h0020_0300, "R5");
    wr(1'b0, 32'h010A_0010, "R7");
    run(6'b000000, 1'b0, "R7");
    chk("R7 parked on 2", 32'(grant), 32'h04);
    run(6'b100101, 1'b0, "R7");
    chk("R7 zero wait grant", 32'(grant), 32'h04);
    run(6'b100101, 1'b1, "R7");
    chk("R7 owner 2", 32'(owner), 32'h2);
    run(6'b100001, 1'b0, "R5");
    chk("R5 level 2 beats level 0", 32'(grant), 32'h20);
    run(6'b000001, 1'b1, "R5");
    run(6'b000000, 1'b1, "R5");
    run(6'b000000, 1'b0, "R7");
    chk("R7 back to parking", 32'(grant), 32'h04);

    // R11: single-cycle parked access
    run(6'b000100, 1'b1, "R11");
    run(6'b000000, 1'b0, "R11");
    chk("R11 stays idle", 32'(owner_vld), 32'h0);
    chk("R11 still parked", 32'(grant), 32'h04);

    // R5 tie break
    wr(1'b1, 32'h0000_0000, "R5");
    run(6'b110000, 1'b0, "R5");
    run(6'b110000, 1'b1, "R5");
    chk("R5 tie lowest number", 32'(grant), 32'h10);
    run(6'b000000, 1'b1, "R5");

    // R8: last-owner parking
    wr(1'b0, 32'h0001_0010, "R8");
    run(6'b000000, 1'b0, "R8");
    chk("R8 parked on last owner", 32'(grant), 32'h20);

    // R6: parked master number out of range parks nowhere
    wr(1'b0, 32'h001E_0010, "R6");
    run(6'b000000, 1'b0, "R6");
    chk("R6 out of range park", 32'(grant), 32'h0);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 150 == 75) begin
        logic [31:0] d;
        d = $urandom;
        d[7:0] = 8'($urandom % 8);
        step(6'($urandom), 1'($urandom % 4 == 0), 1'b1, 1'($urandom % 2), d, "R2 R6 random");
      end else begin
        logic [NM-1:0] r;
        r = '0;
        for (int m = 0; m < NM; m++) r[m] = ($urandom % 10) < 3;
        run(r, 1'($urandom % 4 == 0), "R2 random");
      end
    end

    summary();
    $finish;
  end

endmodule